// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor. The distributor forwards interrupt events to it. Each event carries an ID, a priority value and, for software-generated IDs, the number of the processor that raised it. The block keeps a pending bit and an active bit for every ID. It picks the best eligible pending ID and raises a single request line to the processor while one exists.

The processor talks to the block through a small register port. A read of the acknowledge register returns the chosen ID and moves that ID from pending to active. A write to the end-of-interrupt register retires an active ID. A priority mask register keeps back any interrupt whose priority value is not numerically below the mask. An enable bit gates all signalling. IDs 0–15 are software-generated. Each carries a source-processor field, and that field must be written back unchanged to retire the ID. The valid ID range is 0–510, further limited by the `NUM_IDS` parameter.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the enable bit is 0, the mask reads 0, no ID is pending or active, `irq_out` is low and an acknowledge read returns 1023.
- R2: Register addresses: 0 is control (bit 0 is the enable), 1 is the priority mask (low `PRIO_W` bits), 2 is acknowledge and 3 is end-of-interrupt. Control and mask read back what was written, and all other bits read as zero.
- R3: `irq_out` is high exactly when the enable bit is set and some ID is pending, not active, and has a priority value below the mask.
- R4: Among the eligible IDs, the one with the lowest priority value is chosen. Ties go to the lowest ID.
- R5: An acknowledge read returns the ID in bits [9:0] and the source field in bits [13:10], with all higher bits zero. The source field holds the recorded source processor for IDs 0–15 and zero for other IDs. On the read's clock edge the ID leaves pending and becomes active.
- R6: When the interface is disabled or nothing is eligible, an acknowledge read returns 1023 and changes no state.
- R7: An active ID is not presented again, even if it is forwarded again, until it has been retired. Once retired, a pending copy is presented again.
- R8: An end-of-interrupt write with an ID of 16 or more in bits [9:0] clears that ID's active bit. IDs at or above `NUM_IDS` are ignored.
- R9: An end-of-interrupt write for an ID below 16 retires it only when bits [13:10] equal the source field returned by its acknowledge. Otherwise the write is ignored.
- R10: A forwarded event with an ID below `NUM_IDS` sets the ID pending and stores its priority, and for IDs below 16 it also stores its source. An event with a larger ID is ignored. An event that arrives in the same cycle as the acknowledge of that ID leaves the ID pending.
- R11: A priority value equal to the mask is not signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_set | input | 1 | Forwarded interrupt event strobe |
| fwd_id | input | 10 | ID of the forwarded event |
| fwd_prio | input | PRIO_W | Priority value of the forwarded event |
| fwd_src | input | SRC_W | Source processor of a software-generated event |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The main selection path is exercised with a sweep in which all 64 IDs are pending at once. Their priorities are spread with a modular formula so that many ties occur, which separates the priority-first ordering from ID-first ordering. The sweep is run once under a mask that lets only part of the set through, which shows whether the mask comparison is strict. It is then run again under an open mask to drain the rest. Directed sequences cover the remaining cases:
- an ID re-forwarded while it is active;
- a software-generated ID retired first with a wrong source field and then with the correct one;
- a forwarded event that meets the acknowledge of the same ID in one cycle;
- an out-of-range forward.

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int NUM_IDS = 64,
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_set,
  input  logic [9:0]        fwd_id,
  input  logic [PRIO_W-1:0] fwd_prio,
  input  logic [SRC_W-1:0]  fwd_src,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  localparam int NIDS  = (NUM_IDS > 511) ? 511 : NUM_IDS;
  localparam int IW    = $clog2(NIDS);
  localparam int NSGI  = 16;
  localparam int HI_W  = 32 - 10 - SRC_W;
  localparam logic [9:0] SPURIOUS = 10'd1023;

  logic [NIDS-1:0]   pend_q, act_q;
  logic [PRIO_W-1:0] prio_q    [NIDS];
  logic [SRC_W-1:0]  src_q     [NSGI];
  logic [SRC_W-1:0]  act_src_q [NSGI];
  logic              en_q;
  logic [PRIO_W-1:0] pmr_q;

  logic              found;
  logic [9:0]        best_id;
  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NIDS; i++) begin
      if (pend_q[i] && !act_q[i] && (prio_q[i] < pmr_q) &&
          (!found || prio_q[i] < best_prio)) begin
        found     = 1'b1;
        best_id   = 10'(i);
        best_prio = prio_q[i];
      end
    end
  end

  wire              give     = en_q && found;
  wire              best_sgi = best_id < 10'(NSGI);
  wire [SRC_W-1:0]  best_src = best_sgi ? src_q[best_id[3:0]] : '0;
  wire [31:0]       ack_val  = give ? {{HI_W{1'b0}}, best_src, best_id} : {22'd0, SPURIOUS};
  wire              do_ack   = reg_rd && reg_addr == 2'd2 && give;

  wire [9:0]        e_id     = reg_wdata[9:0];
  wire [SRC_W-1:0]  e_src    = reg_wdata[10 +: SRC_W];
  wire              e_sgi    = e_id < 10'(NSGI);
  wire              eoi_wr   = reg_wr && reg_addr == 2'd3;
  wire              eoi_ok   = eoi_wr && e_id < 10'(NIDS) &&
                               (!e_sgi || e_src == act_src_q[e_id[3:0]]);
  wire              set_ok   = fwd_set && fwd_id < 10'(NIDS);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'd0, en_q};
      2'd1:    reg_rdata = {{(32-PRIO_W){1'b0}}, pmr_q};
      2'd2:    reg_rdata = ack_val;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_out = give;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pmr_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
      for (int i = 0; i < NIDS; i++) prio_q[i] <= '0;
      for (int i = 0; i < NSGI; i++) begin
        src_q[i]     <= '0;
        act_src_q[i] <= '0;
      end
    end else begin
      if (reg_wr && reg_addr == 2'd0) en_q  <= reg_wdata[0];
      if (reg_wr && reg_addr == 2'd1) pmr_q <= reg_wdata[PRIO_W-1:0];
      if (do_ack && best_sgi) act_src_q[best_id[3:0]] <= best_src;
      if (set_ok && fwd_id < 10'(NSGI)) src_q[fwd_id[3:0]] <= fwd_src;
      for (int i = 0; i < NIDS; i++) begin
        if (do_ack && best_id == 10'(i)) begin
          pend_q[i] <= 1'b0;
          act_q[i]  <= 1'b1;
        end
        if (eoi_ok && e_id == 10'(i)) act_q[i] <= 1'b0;
        if (set_ok && fwd_id == 10'(i)) begin
          pend_q[i] <= 1'b1;
          prio_q[i] <= fwd_prio;
        end
      end
    end
  end

  // R5: an acknowledged ID is active on the next cycle
  a_r5_ack_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && !reg_wr) |=> act_q[$past(best_id[IW-1:0])]);

  // R6: a spurious acknowledge leaves pending and active untouched
  a_r6_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !give && !fwd_set && !reg_wr)
      |=> ($stable(pend_q) && $stable(act_q)));

  // R8: a valid retire of a non-software ID clears its active bit
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !e_sgi && e_id < 10'(NIDS) && !reg_rd)
      |=> !act_q[$past(e_id[IW-1:0])]);

  // R9: a software ID retired with the wrong source field stays active
  a_r9_src_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && e_sgi && e_src != act_src_q[e_id[3:0]] && !reg_rd)
      |=> $stable(act_q));

  // R10: an in-range forwarded event leaves its ID pending
  a_r10_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_set && fwd_id < 10'(NIDS)) |=> pend_q[$past(fwd_id[IW-1:0])]);
endmodule

// File: tb/irq_cpu_port_tb.sv
`timescale 1ns/1ps
module irq_cpu_port_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fwd_set = 1'b0;
  logic [9:0]  fwd_id = '0;
  logic [7:0]  fwd_prio = '0;
  logic [3:0]  fwd_src = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  logic       m_pend [N];
  logic       m_act  [N];
  logic [7:0] m_prio [N];
  logic [3:0] m_src  [N];

  irq_cpu_port #(.NUM_IDS(N), .PRIO_W(8), .SRC_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_set(fwd_set), .fwd_id(fwd_id),
    .fwd_prio(fwd_prio), .fwd_src(fwd_src), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic fwd(input int id, input logic [7:0] p, input logic [3:0] s);
    @(negedge clk);
    fwd_set = 1'b1; fwd_id = 10'(id); fwd_prio = p; fwd_src = s;
    @(posedge clk); #1;
    fwd_set = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic irq_is(input string req, input logic e);
    @(negedge clk); #1;
    chk(req, {31'd0, irq_out}, {31'd0, e});
  endtask

  function automatic logic [7:0] prio_of(input int id);
    return 8'(((id * 5) % 7) * 16);
  endfunction

  function automatic int pick(input logic [7:0] mask);
    int b = 1023;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && !m_act[i] && m_prio[i] < mask &&
          (b == 1023 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  task automatic sweep(input logic [7:0] mask);
    logic [31:0] d;
    int exp_id;
    wr(2'd1, {24'd0, mask});
    for (int k = 0; k <= N; k++) begin
      exp_id = pick(mask);
      rd(2'd2, d);
      if (exp_id == 1023) begin
        chk("R4 sweep end spurious", d, 32'd1023);
        break;
      end
      chk("R4 R5 sweep order", d, (exp_id < 16) ? ({28'd0, m_src[exp_id]} << 10) | 32'(exp_id) : 32'(exp_id));
      m_pend[exp_id] = 1'b0;
      m_act[exp_id]  = 1'b1;
    end
    for (int i = 0; i < N; i++)
      if (m_act[i]) begin
        wr(2'd3, (i < 16) ? ({28'd0, m_src[i]} << 10) | 32'(i) : 32'(i));
        m_act[i] = 1'b0;
      end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(2'd0, d); chk("R1 control reset", d, 32'd0);
    rd(2'd1, d); chk("R1 mask reset", d, 32'd0);
    irq_is("R1 irq low", 1'b0);
    rd(2'd2, d); chk("R1 ack spurious", d, 32'd1023);

    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 control readback", d, 32'd1);
    wr(2'd1, 32'h1234_5680); rd(2'd1, d); chk("R2 mask readback", d, 32'h80);

    fwd(40, 8'h80, 4'd0);
    irq_is("R11 equal to mask held back", 1'b0);
    rd(2'd2, d); chk("R6 ack spurious when masked", d, 32'd1023);
    wr(2'd1, 32'h81);
    irq_is("R3 below mask signalled", 1'b1);
    wr(2'd0, 32'd0);
    irq_is("R3 disabled no irq", 1'b0);
    rd(2'd2, d); chk("R6 ack spurious when disabled", d, 32'd1023);
    wr(2'd0, 32'd1);
    irq_is("R6 pending kept after spurious", 1'b1);
    rd(2'd2, d); chk("R5 ack returns id", d, 32'd40);
    irq_is("R5 acked id no longer signalled", 1'b0);
    fwd(40, 8'h10, 4'd0);
    irq_is("R7 active id not presented", 1'b0);
    wr(2'd3, 32'd40);
    irq_is("R7 R8 presented after retire", 1'b1);
    rd(2'd2, d); chk("R7 re-ack", d, 32'd40);
    wr(2'd3, 32'd40);
    irq_is("R8 retired idle", 1'b0);

    fwd(5, 8'h10, 4'd9);
    rd(2'd2, d); chk("R5 software id with source", d, (32'd9 << 10) | 32'd5);
    fwd(5, 8'h10, 4'd2);
    wr(2'd3, 32'd5);
    irq_is("R9 wrong source ignored", 1'b0);
    wr(2'd3, (32'd9 << 10) | 32'd5);
    irq_is("R9 correct source retires", 1'b1);
    rd(2'd2, d); chk("R10 new source stored", d, (32'd2 << 10) | 32'd5);
    wr(2'd3, (32'd2 << 10) | 32'd5);

    fwd(64, 8'h00, 4'd0);
    irq_is("R10 out of range ignored", 1'b0);
    wr(2'd3, 32'd64);
    rd(2'd2, d); chk("R8 out of range eoi no effect", d, 32'd1023);

    fwd(20, 8'h30, 4'd0);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd2;
    fwd_set = 1'b1; fwd_id = 10'd20; fwd_prio = 8'h30;
    #1 chk("R10 same-cycle ack value", reg_rdata, 32'd20);
    @(posedge clk); #1;
    reg_rd = 1'b0; fwd_set = 1'b0;
    irq_is("R10 same-cycle active blocks", 1'b0);
    wr(2'd3, 32'd20);
    irq_is("R10 same-cycle set kept pending", 1'b1);
    rd(2'd2, d); chk("R10 re-presented", d, 32'd20);
    wr(2'd3, 32'd20);

    for (int i = 0; i < N; i++) begin
      m_pend[i] = 1'b1; m_act[i] = 1'b0;
      m_prio[i] = prio_of(i); m_src[i] = 4'(i % 16);
      fwd(i, m_prio[i], m_src[i]);
    end
    sweep(8'h40);
    irq_is("R3 R11 masked rest held", 1'b0);
    sweep(8'hFF);
    irq_is("R4 all drained", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule